// File: doc/BRIEF.md
# Sequential Shift-Subtract Integer Divider

This block divides one 32-bit integer by another. It produces one quotient bit per clock using a restoring shift-and-subtract loop. A single-cycle start pulse captures the dividend, the divisor and a mode bit that selects unsigned or two's-complement operation. The block then runs on its own until a one-cycle done pulse marks the quotient and remainder as valid. Those results stay on the outputs until the next division completes.

In signed mode, both operands are reduced to magnitudes before the loop. When exactly one operand was negative, both the quotient and the remainder are negated afterwards, so the remainder follows the sign of the quotient. The number of loop passes depends on the data. The block looks at the magnitudes of both operands and finds the whole bytes at the top that are zero in both. For each such byte, up to three, the block saves eight passes by pre-shifting only the dividend. A zero divisor is not trapped and returns a defined pattern.

Top module: `shift_sub_divider`

## Requirements
- R1: In unsigned mode (`signed_i` = 0), `quotient_o` = dividend / divisor and `remainder_o` = dividend mod divisor, for every non-zero divisor.
- R2: The loop runs 32, 24, 16 or 8 passes when the count of top bytes that are zero in both operand magnitudes is 0, 1, 2 or 3 or more. `done_o` rises exactly passes + 1 clock edges after the edge that accepts `start_i`.
- R3: A zero divisor runs the full 32 passes. It yields an all-ones quotient and a remainder equal to the dividend magnitude, before the sign correction of R4.
- R4: In signed mode (`signed_i` = 1), operands whose bit 31 is set are negated to magnitudes. If exactly one operand was negative, both the quotient and the remainder are two's-complement negated. Otherwise both are returned as magnitudes.
- R5: In signed mode, a dividend of 0x80000000 is treated as magnitude 2^31. Dividing it by -1 gives quotient 0x80000000 and remainder 0.
- R6: A `start_i` pulse while a division is in progress is ignored. The running division keeps its operands and its timing.
- R7: `done_o` is high for exactly one cycle per division. `quotient_o` and `remainder_o` change only on the edge that raises `done_o`.
- R8: After reset, `busy_o` and `done_o` are 0, and `quotient_o` and `remainder_o` are 0.
- R9: `busy_o` is high from the edge that accepts `start_i` until the edge that raises `done_o`, and it is low while `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a division when idle |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend_i | input | 32 | Dividend, sampled with start |
| divisor_i | input | 32 | Divisor, sampled with start |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| quotient_o | output | 32 | Quotient, held until the next completion |
| remainder_o | output | 32 | Remainder, held until the next completion |

## Verification
The tests use operands confined to one, two, three and four significant bytes. Dividend and divisor get different widths, so the measured latency shows whether the skip decision is based on the two operands jointly rather than on either one alone. Signed vectors cover all four sign combinations, which separates a remainder that follows the quotient's sign from one that follows the dividend's. The most negative dividend exercises the 2^31 magnitude. Zero divisors are tried with short and negative dividends, which shows that skipping is disabled and that the sign correction still applies. A start pulse during a long division, and the cycles that follow a done pulse, confirm that the returned results belong to the first operands only.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } sdiv_state_t;

endpackage

// File: rtl/sdiv_operand_prep.sv
module sdiv_operand_prep #(
   parameter int DATA_W  = 32,
   parameter int CHUNK_W = 8,
   parameter bit SKIP_EN = 1'b1,
   localparam int CNT_W  = $clog2(DATA_W + 1)
) (
   input  logic              signed_i,
   input  logic [DATA_W-1:0] dividend_i,
   input  logic [DATA_W-1:0] divisor_i,
   output logic [DATA_W-1:0] dividend_o,
   output logic [DATA_W-1:0] divisor_o,
   output logic              neg_res_o,
   output logic [CNT_W-1:0]  iters_o
);

   localparam int NCHUNK = DATA_W / CHUNK_W;
   localparam int SK_W   = $clog2(NCHUNK);

   logic              a_neg, b_neg;
   logic [DATA_W-1:0] mag_a, mag_b;
   logic [SK_W-1:0]   skip;
   int                shamt;

   assign a_neg     = signed_i & dividend_i[DATA_W-1];
   assign b_neg     = signed_i & divisor_i[DATA_W-1];
   assign mag_a     = a_neg ? (~dividend_i + 1'b1) : dividend_i;
   assign mag_b     = b_neg ? (~divisor_i + 1'b1) : divisor_i;
   assign neg_res_o = a_neg ^ b_neg;

   generate
      if (SKIP_EN) begin : g_skip
         always_comb begin
            logic still_zero;
            still_zero = 1'b1;
            skip       = '0;
            for (int i = 0; i < NCHUNK - 1; i++) begin
               if (still_zero &&
                   (mag_a[DATA_W-1-i*CHUNK_W -: CHUNK_W] == '0) &&
                   (mag_b[DATA_W-1-i*CHUNK_W -: CHUNK_W] == '0)) begin
                  skip = SK_W'(i + 1);
               end else begin
                  still_zero = 1'b0;
               end
            end
            if (mag_b == '0) skip = '0;
         end
      end else begin : g_noskip
         assign skip = '0;
      end
   endgenerate

   assign shamt      = int'(skip) * CHUNK_W;
   assign dividend_o = mag_a << shamt;
   assign divisor_o  = mag_b;
   assign iters_o    = CNT_W'(DATA_W - shamt);

endmodule

// File: rtl/sdiv_step.sv
module sdiv_step #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              step_i,
   input  logic [DATA_W-1:0] dividend_i,
   input  logic [DATA_W-1:0] divisor_i,
   output logic [DATA_W-1:0] quo_o,
   output logic [DATA_W-1:0] rem_o
);

   logic [DATA_W-1:0] quo_q, rem_q, div_q;
   logic [DATA_W:0]   rem_sh;
   logic [DATA_W+1:0] diff;
   logic              borrow;

   assign rem_sh = {rem_q, quo_q[DATA_W-1]};
   assign diff   = {1'b0, rem_sh} - {2'b00, div_q};
   assign borrow = diff[DATA_W+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quo_q <= '0;
         rem_q <= '0;
         div_q <= '0;
      end else if (load_i) begin
         quo_q <= dividend_i;
         rem_q <= '0;
         div_q <= divisor_i;
      end else if (step_i) begin
         quo_q <= {quo_q[DATA_W-2:0], ~borrow};
         rem_q <= borrow ? rem_sh[DATA_W-1:0] : diff[DATA_W-1:0];
      end
   end

   assign quo_o = quo_q;
   assign rem_o = rem_q;

   // R1: the partial remainder never reaches the divisor
   p_rem_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (div_q != '0) |-> (rem_q < div_q));

endmodule

// File: rtl/sdiv_ctrl.sv
module sdiv_ctrl
   import sdiv_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int CHUNK_W = 8,
   localparam int CNT_W  = $clog2(DATA_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] iters_i,
   output logic             load_o,
   output logic             step_o,
   output logic             fin_o,
   output logic             busy_o
);

   sdiv_state_t      state_q;
   logic [CNT_W-1:0] cnt_q;

   assign load_o = (state_q == ST_IDLE) && start_i;
   assign step_o = (state_q == ST_RUN);
   assign fin_o  = (state_q == ST_FIN);
   assign busy_o = (state_q != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (start_i) begin
               state_q <= ST_RUN;
               cnt_q   <= iters_i;
            end
            ST_RUN: begin
               cnt_q <= cnt_q - 1'b1;
               if (cnt_q == CNT_W'(1)) state_q <= ST_FIN;
            end
            ST_FIN:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R2: a loaded pass count is a non-zero whole number of chunks
   p_load_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load_o |=> (state_q == ST_RUN) && (cnt_q != '0) &&
                 (int'(cnt_q) % CHUNK_W == 0) && (int'(cnt_q) <= DATA_W));

   // R6: a start seen while running leaves the pass counter running down
   p_ignore_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_o && start_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/shift_sub_divider.sv
module shift_sub_divider #(
   parameter int DATA_W  = 32,
   parameter int CHUNK_W = 8,
   parameter bit SKIP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              signed_i,
   input  logic [DATA_W-1:0] dividend_i,
   input  logic [DATA_W-1:0] divisor_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] quotient_o,
   output logic [DATA_W-1:0] remainder_o
);

   localparam int CNT_W = $clog2(DATA_W + 1);

   generate
      if (DATA_W % CHUNK_W != 0) begin : g_bad_chunk
         $error("DATA_W must be a multiple of CHUNK_W");
      end
      if (DATA_W / CHUNK_W < 2) begin : g_bad_count
         $error("DATA_W must hold at least two chunks");
      end
   endgenerate

   logic [DATA_W-1:0] prep_a, prep_b, quo, rem;
   logic              prep_neg, neg_q;
   logic [CNT_W-1:0]  prep_iters;
   logic              load, step, fin;

   sdiv_operand_prep #(.DATA_W(DATA_W), .CHUNK_W(CHUNK_W), .SKIP_EN(SKIP_EN)) u_prep (
      .signed_i   (signed_i),
      .dividend_i (dividend_i),
      .divisor_i  (divisor_i),
      .dividend_o (prep_a),
      .divisor_o  (prep_b),
      .neg_res_o  (prep_neg),
      .iters_o    (prep_iters)
   );

   sdiv_ctrl #(.DATA_W(DATA_W), .CHUNK_W(CHUNK_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .iters_i (prep_iters),
      .load_o  (load),
      .step_o  (step),
      .fin_o   (fin),
      .busy_o  (busy_o)
   );

   sdiv_step #(.DATA_W(DATA_W)) u_step (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .step_i     (step),
      .dividend_i (prep_a),
      .divisor_i  (prep_b),
      .quo_o      (quo),
      .rem_o      (rem)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         neg_q       <= 1'b0;
         done_o      <= 1'b0;
         quotient_o  <= '0;
         remainder_o <= '0;
      end else begin
         if (load) neg_q <= prep_neg;
         done_o <= fin;
         if (fin) begin
            quotient_o  <= neg_q ? (~quo + 1'b1) : quo;
            remainder_o <= neg_q ? (~rem + 1'b1) : rem;
         end
      end
   end

   // R7: done lasts a single cycle
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R7: results move only together with done
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(quotient_o) && $stable(remainder_o)));

   // R9: busy is low while done is shown
   p_busy_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

endmodule

// File: tb/tb_shift_sub_divider.sv
module tb_shift_sub_divider;

   localparam int VW = 135;
   localparam int NV = 13;
   // {signed, dividend, divisor, quotient, remainder, passes}
   localparam logic [VW-1:0] VECS [NV] = '{
      {1'b0, 32'd100,        32'd7,        32'd14,       32'd2,        6'd8},
      {1'b0, 32'hFFFFFFFF,   32'd1,        32'hFFFFFFFF, 32'd0,        6'd32},
      {1'b0, 32'h00012345,   32'h10,       32'h1234,     32'd5,        6'd24},
      {1'b0, 32'h0000FFFF,   32'h100,      32'hFF,       32'hFF,       6'd16},
      {1'b0, 32'd1234,       32'd0,        32'hFFFFFFFF, 32'd1234,     6'd32},
      {1'b1, 32'hFFFFFFF9,   32'd2,        32'hFFFFFFFD, 32'hFFFFFFFF, 6'd8},
      {1'b1, 32'd7,          32'hFFFFFFFE, 32'hFFFFFFFD, 32'hFFFFFFFF, 6'd8},
      {1'b1, 32'hFFFFFFF9,   32'hFFFFFFFE, 32'd3,        32'd1,        6'd8},
      {1'b1, 32'h80000000,   32'hFFFFFFFF, 32'h80000000, 32'd0,        6'd32},
      {1'b1, 32'hFFFFFFFB,   32'd0,        32'd1,        32'hFFFFFFFB, 6'd32},
      {1'b0, 32'h80000000,   32'hFFFFFFFF, 32'd0,        32'h80000000, 6'd32},
      {1'b0, 32'd0,          32'd5,        32'd0,        32'd0,        6'd8},
      {1'b0, 32'h00ABCDEF,   32'h00ABCDEF, 32'd1,        32'd0,        6'd24}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        signed_i = 1'b0;
   logic [31:0] dividend_i = '0;
   logic [31:0] divisor_i = '0;
   logic        busy_o, done_o;
   logic [31:0] quotient_o, remainder_o;

   int n_checks = 0;
   int n_fail = 0;
   int cycles = 0;

   shift_sub_divider dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
      .dividend_i(dividend_i), .divisor_i(divisor_i), .busy_o(busy_o),
      .done_o(done_o), .quotient_o(quotient_o), .remainder_o(remainder_o)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic model(input logic m, input logic [31:0] a, input logic [31:0] b,
                        output logic [31:0] q, output logic [31:0] r, output int it);
      logic an, bn;
      logic [31:0] ma, mb;
      an = m & a[31];
      bn = m & b[31];
      ma = an ? -a : a;
      mb = bn ? -b : b;
      if (mb == 0) begin
         q = '1; r = ma; it = 32;
      end else begin
         q = ma / mb; r = ma % mb;
         if (ma[31:8] == 0 && mb[31:8] == 0) it = 8;
         else if (ma[31:16] == 0 && mb[31:16] == 0) it = 16;
         else if (ma[31:24] == 0 && mb[31:24] == 0) it = 24;
         else it = 32;
      end
      if (an ^ bn) begin
         q = -q; r = -r;
      end
   endtask

   task automatic run(input logic m, input logic [31:0] a, input logic [31:0] b,
                      output int lat);
      @(negedge clk);
      signed_i = m; dividend_i = a; divisor_i = b; start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      lat = 0;
      for (int k = 0; k < 100; k++) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
         if (done_o) break;
      end
   endtask

   task automatic one(input string rq, input logic m, input logic [31:0] a,
                      input logic [31:0] b, input logic [31:0] eq, input logic [31:0] er,
                      input int eit);
      int lat;
      run(m, a, b, lat);
      chk({rq, " quotient"}, quotient_o, eq);
      chk({rq, " remainder"}, remainder_o, er);
      chk("R2 latency", 32'(lat), 32'(eit + 1));
   endtask

   initial begin
      logic [31:0] mq, mr, a, b, m_a, m_b;
      int mit, lat;
      logic md;
      repeat (3) @(negedge clk);
      // R8: reset values
      chk("R8 busy", {31'b0, busy_o}, 32'd0);
      chk("R8 done", {31'b0, done_o}, 32'd0);
      chk("R8 quotient", quotient_o, 32'd0);
      chk("R8 remainder", remainder_o, 32'd0);
      rst_n = 1'b1;

      // table walk: R1 unsigned, R3 zero divisor, R4 signs, R5 most negative
      for (int v = 0; v < NV; v++) begin
         string rq;
         rq = VECS[v][134] ? "R4" : "R1";
         if (VECS[v][101:70] == 0) rq = "R3";
         if (v == 8) rq = "R5";
         one(rq, VECS[v][134], VECS[v][133:102], VECS[v][101:70],
             VECS[v][69:38], VECS[v][37:6], int'(VECS[v][5:0]));
      end

      // random against the model, with operands limited to various byte widths
      for (int n = 0; n < 80; n++) begin
         m_a = 32'hFFFFFFFF >> (8 * ($urandom % 4));
         m_b = 32'hFFFFFFFF >> (8 * ($urandom % 4));
         a = $urandom & m_a;
         b = $urandom & m_b;
         if ($urandom % 8 == 0) b = 0;
         md = 1'($urandom % 2);
         if (md && ($urandom % 3 == 0)) a = -a;
         if (md && ($urandom % 3 == 0)) b = -b;
         model(md, a, b, mq, mr, mit);
         one(md ? "R4" : "R1", md, a, b, mq, mr, mit);
      end

      // R9: busy during a run
      @(negedge clk);
      signed_i = 0; dividend_i = 32'hFFFFFFFF; divisor_i = 3; start_i = 1;
      @(posedge clk); @(negedge clk);
      start_i = 0;
      chk("R9 busy while running", {31'b0, busy_o}, 32'd1);
      // R6: start during run with other operands
      repeat (4) @(negedge clk);
      signed_i = 1; dividend_i = 10; divisor_i = 3; start_i = 1;
      @(negedge clk);
      start_i = 0;
      lat = 5;
      for (int k = 0; k < 100; k++) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
         if (done_o) break;
      end
      chk("R6 quotient of first operands", quotient_o, 32'h55555555);
      chk("R6 remainder of first operands", remainder_o, 32'd0);
      chk("R6 latency unchanged", 32'(lat), 32'd33);
      chk("R9 busy low at done", {31'b0, busy_o}, 32'd0);
      // R7: single pulse and held results
      @(negedge clk);
      chk("R7 done one cycle", {31'b0, done_o}, 32'd0);
      repeat (5) @(negedge clk);
      chk("R7 quotient held", quotient_o, 32'h55555555);
      chk("R7 remainder held", remainder_o, 32'd0);
      chk("R7 done stays low", {31'b0, done_o}, 32'd0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule